// File: doc/BRIEF.md
# Programmable PLL Feedback Divider

This block is the integer divider in the feedback path of a frequency synthesizer. It divides its input clock by a ratio of 2·(base + 4) + odd. The base term is ten bits wide and the odd term is one bit wide, so any ratio from 8 to 2055 can be reached, odd or even. The ratio fields arrive through a byte-wide write port as three 8-bit configuration registers at addresses 0x40, 0x41 and 0x42. The ten-bit base is split across two of these registers.

Two values share those registers with the ratio fields but do not affect the division. One is a 3-bit loop-gain (charge-pump) setting. The other is a 7-bit field owned by the reference divider. Both are stored and returned through a combinational read port. The outputs are the divided clock and a one-cycle terminal-count pulse. A ratio written at any time takes effect only at the next terminal count, so no output period is cut short.

Top module: `fbdiv_top`

## Requirements
- R1: The output period, in input clock cycles, equals 2·(PB + 4) + PO. The smallest value is 8 (PB = 0, PO = 0) and the largest is 2055 (PB = 1023, PO = 1).
- R2: PB[9:8] is taken from bits 1:0 of register 0x40. PB[7:0] is register 0x41. PO is bit 7 of register 0x42.
- R3: Bits 7:5 of register 0x40 always read as 0, whatever value was written to them.
- R4: Bits 4:2 of register 0x40 hold a 3-bit loop-gain setting that reads back as written and has no effect on the output period.
- R5: A ratio written during a period takes effect only after the next terminal count. The period in progress completes with its old length.
- R6: Each period starts with the output high. The high time is ratio/2 cycles for an even ratio and (ratio+1)/2 cycles for an odd ratio. The output is low for the rest of the period.
- R7: The terminal-count output is high for exactly one cycle, the last input cycle of each output period.
- R8: A synchronous active-high reset clears all three registers to 0, clears the counter and loads ratio 8.
- R9: Bits 6:0 of register 0x42 hold the reference-divider field. It reads back as written and has no effect on the output period.
- R10: A write to any address other than 0x40, 0x41 or 0x42 changes nothing. A read from such an address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock to be divided |
| rst_i | input | 1 | Synchronous reset, active high |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 8 | Register write address |
| wr_data_i | input | 8 | Register write data |
| rd_addr_i | input | 8 | Register read address |
| rd_data_o | output | 8 | Read data, combinational from rd_addr_i |
| div_clk_o | output | 1 | Divided clock |
| tc_o | output | 1 | Terminal-count pulse, last cycle of each period |

## Verification
A table of base and odd values drives the divider through several settings. The set covers both extremes and the even neighbour of the maximum, which separates the +4 offset, the doubling and the odd bit from one another. It also includes a value that touches only the top base bits and an alternating bit pattern that shows whether the register split is assembled in the right order.

Writes held through an entire period, in both the growing and the shrinking direction, show whether a new ratio leaks into the period in progress. Further checks write the loop-gain bits, the reserved bits, the reference-divider bits and unmapped addresses. In each case the period measured afterwards and the values read back show that only the intended fields changed.

// File: rtl/fbdiv_pkg.sv
package fbdiv_pkg;
    localparam int BYTE_W     = 8;
    localparam int PB_W       = 10;
    localparam int PB_HI_W    = PB_W - BYTE_W;
    localparam int CP_W       = 3;
    localparam int QR_W       = BYTE_W - 1;
    localparam int RSV_W      = BYTE_W - CP_W - PB_HI_W;
    localparam int RATIO_W    = PB_W + 2;
    localparam int RATIO_BASE = 4;
    localparam int RATIO_MIN  = 2 * RATIO_BASE;
    localparam int RATIO_MAX  = 2 * ((1 << PB_W) - 1 + RATIO_BASE) + 1;

    localparam logic [BYTE_W-1:0] ADDR_PBHI = 8'h40;
    localparam logic [BYTE_W-1:0] ADDR_PBLO = 8'h41;
    localparam logic [BYTE_W-1:0] ADDR_ODDQ = 8'h42;

    typedef struct packed {
        logic [PB_W-1:0] pb;
        logic            po;
        logic [CP_W-1:0] cp;
        logic [QR_W-1:0] qref;
    } cfg_t;

    typedef struct packed {
        logic [RATIO_W-1:0] cnt;
        logic [RATIO_W-1:0] ratio;
        logic [RATIO_W-1:0] hi_len;
    } div_st_t;
endpackage

// File: rtl/fbdiv_regs.sv
module fbdiv_regs
    import fbdiv_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              wr_en_i,
    input  logic [BYTE_W-1:0] wr_addr_i,
    input  logic [BYTE_W-1:0] wr_data_i,
    input  logic [BYTE_W-1:0] rd_addr_i,
    output logic [BYTE_W-1:0] rd_data_o,
    output cfg_t              cfg_o
);
    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en_i) begin
            case (wr_addr_i)
                ADDR_PBHI: begin
                    cfg_d.pb[PB_W-1:BYTE_W] = wr_data_i[PB_HI_W-1:0];
                    cfg_d.cp                = wr_data_i[PB_HI_W+CP_W-1:PB_HI_W];
                end
                ADDR_PBLO: cfg_d.pb[BYTE_W-1:0] = wr_data_i;
                ADDR_ODDQ: begin
                    cfg_d.po   = wr_data_i[BYTE_W-1];
                    cfg_d.qref = wr_data_i[QR_W-1:0];
                end
                default: cfg_d = cfg_q;
            endcase
        end
        if (rst_i) begin
            cfg_d = '0;
        end
    end

    always_ff @(posedge clk_i) begin
        cfg_q <= cfg_d;
    end

    always_comb begin
        case (rd_addr_i)
            ADDR_PBHI: rd_data_o = {{RSV_W{1'b0}}, cfg_q.cp, cfg_q.pb[PB_W-1:BYTE_W]};
            ADDR_PBLO: rd_data_o = cfg_q.pb[BYTE_W-1:0];
            ADDR_ODDQ: rd_data_o = {cfg_q.po, cfg_q.qref};
            default:   rd_data_o = '0;
        endcase
    end

    assign cfg_o = cfg_q;

    // R8: registers clear on reset
    a_r8_regs_clear: assert property (@(posedge clk_i) rst_i |=> (cfg_q == '0));
    // R10: a write to an unmapped address leaves every field alone
    a_r10_unmapped_write: assert property (@(posedge clk_i) disable iff (rst_i)
        (wr_en_i && wr_addr_i != ADDR_PBHI && wr_addr_i != ADDR_PBLO && wr_addr_i != ADDR_ODDQ)
        |=> $stable(cfg_q));
endmodule

// File: rtl/fbdiv_ratio.sv
module fbdiv_ratio
    import fbdiv_pkg::*;
(
    input  logic [PB_W-1:0]    pb_i,
    input  logic               po_i,
    output logic [RATIO_W-1:0] ratio_o,
    output logic [RATIO_W-1:0] hi_len_o
);
    logic [PB_W:0] pb_off;

    always_comb begin
        pb_off   = {1'b0, pb_i} + (PB_W+1)'(RATIO_BASE);
        ratio_o  = {pb_off, po_i};
        hi_len_o = RATIO_W'(pb_off) + RATIO_W'(po_i);
    end
endmodule

// File: rtl/fbdiv_counter.sv
module fbdiv_counter
    import fbdiv_pkg::*;
(
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic [RATIO_W-1:0] ratio_new_i,
    input  logic [RATIO_W-1:0] hi_new_i,
    output logic               div_clk_o,
    output logic               tc_o
);
    div_st_t st_d, st_q;
    logic    tc;

    always_comb begin
        tc   = (st_q.cnt == (st_q.ratio - RATIO_W'(1)));
        st_d = st_q;
        if (tc) begin
            st_d.cnt    = '0;
            st_d.ratio  = ratio_new_i;
            st_d.hi_len = hi_new_i;
        end else begin
            st_d.cnt = st_q.cnt + RATIO_W'(1);
        end
        if (rst_i) begin
            st_d.cnt    = '0;
            st_d.ratio  = RATIO_W'(RATIO_MIN);
            st_d.hi_len = RATIO_W'(RATIO_MIN / 2);
        end
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    assign tc_o      = tc;
    assign div_clk_o = (st_q.cnt < st_q.hi_len);

    // R5: active ratio only moves across a terminal count
    a_r5_ratio_hold: assert property (@(posedge clk_i) disable iff (rst_i)
        !tc_o |=> $stable(st_q.ratio));
    // R7: terminal count never lasts two cycles
    a_r7_tc_single: assert property (@(posedge clk_i) disable iff (rst_i)
        tc_o |=> !tc_o);
    // R6: a new period opens with the output high
    a_r6_high_at_start: assert property (@(posedge clk_i) disable iff (rst_i)
        tc_o |=> div_clk_o);
    // R1: active ratio stays within the legal span
    a_r1_ratio_range: assert property (@(posedge clk_i) disable iff (rst_i)
        (st_q.ratio >= RATIO_W'(RATIO_MIN)) && (st_q.ratio <= RATIO_W'(RATIO_MAX)));
    // R8: reset leaves ratio 8 and a cleared count
    a_r8_reset_load: assert property (@(posedge clk_i)
        rst_i |=> (st_q.cnt == '0 && st_q.ratio == RATIO_W'(RATIO_MIN)));
endmodule

// File: rtl/fbdiv_top.sv
module fbdiv_top
    import fbdiv_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              wr_en_i,
    input  logic [BYTE_W-1:0] wr_addr_i,
    input  logic [BYTE_W-1:0] wr_data_i,
    input  logic [BYTE_W-1:0] rd_addr_i,
    output logic [BYTE_W-1:0] rd_data_o,
    output logic              div_clk_o,
    output logic              tc_o
);
    cfg_t               cfg;
    logic [RATIO_W-1:0] ratio_new;
    logic [RATIO_W-1:0] hi_new;

    fbdiv_regs u_regs (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .rd_addr_i (rd_addr_i),
        .rd_data_o (rd_data_o),
        .cfg_o     (cfg)
    );

    fbdiv_ratio u_ratio (
        .pb_i     (cfg.pb),
        .po_i     (cfg.po),
        .ratio_o  (ratio_new),
        .hi_len_o (hi_new)
    );

    fbdiv_counter u_cnt (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .ratio_new_i (ratio_new),
        .hi_new_i    (hi_new),
        .div_clk_o   (div_clk_o),
        .tc_o        (tc_o)
    );

    // R3: reserved bits of the high base register read as zero
    a_r3_rsv_zero: assert property (@(posedge clk_i) disable iff (rst_i)
        (rd_addr_i == ADDR_PBHI) |-> (rd_data_o[BYTE_W-1:BYTE_W-RSV_W] == '0));
endmodule

// File: tb/fbdiv_top_tb_top.sv
`timescale 1ns/1ps
module fbdiv_top_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       div_clk;
    logic       tc;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    fbdiv_top dut_i (
        .clk_i     (clk),
        .rst_i     (rst),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (wr_data),
        .rd_addr_i (rd_addr),
        .rd_data_o (rd_data),
        .div_clk_o (div_clk),
        .tc_o      (tc)
    );

    localparam int VEC_N = 9;
    localparam int VPB  [VEC_N] = '{0, 0, 1, 5, 100, 341, 1023, 1023, 256};
    localparam int VPO  [VEC_N] = '{0, 1, 0, 1, 0,   1,   1,    0,    0};
    localparam int VRAT [VEC_N] = '{8, 9, 10, 19, 208, 691, 2055, 2054, 520};
    localparam int VHI  [VEC_N] = '{4, 5, 5,  10, 104, 346, 1028, 1027, 260};

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input int exp);
        rd_addr = a;
        #1;
        chk(req, int'(rd_data), exp);
    endtask

    task automatic wr_cfg(input int pb, input int po, input int cp, input int q);
        wr(8'h40, 8'((cp << 2) | (pb >> 8)));
        wr(8'h41, 8'(pb & 255));
        wr(8'h42, 8'((po << 7) | q));
    endtask

    // leaves the bench at the first negedge of a fresh period
    task automatic sync_tc();
        while (!tc) @(negedge clk);
        @(negedge clk);
    endtask

    // from a period start, counts one period; ends at the next start
    task automatic measure(output int n, output int h, output int tcs);
        n = 0; h = 0; tcs = 0;
        forever begin
            n++;
            h += int'(div_clk);
            if (tc) break;
            @(negedge clk);
        end
        tcs = 1;
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int n, h, t;
        repeat (4) @(negedge clk);
        // R8: reset state
        rd_chk("R8 reg40", 8'h40, 0);
        rd_chk("R8 reg41", 8'h41, 0);
        rd_chk("R8 reg42", 8'h42, 0);
        chk("R8 out high at reset", int'(div_clk), 1);
        chk("R7 no tc at reset", int'(tc), 0);
        rst = 1'b0;
        measure(n, h, t);
        chk("R8 first period 8", n, 8);
        chk("R6 first high 4", h, 4);

        // R1/R2/R6/R7: vector table
        for (int i = 0; i < VEC_N; i++) begin
            wr_cfg(VPB[i], VPO[i], 0, 0);
            sync_tc();
            measure(n, h, t);
            chk($sformatf("R1 R2 period vec%0d", i), n, VRAT[i]);
            chk($sformatf("R6 high vec%0d", i), h, VHI[i]);
            chk($sformatf("R7 tc once vec%0d", i), t, 1);
        end

        // R5: grow 40 -> 41 written during a period
        wr_cfg(16, 0, 0, 0);
        sync_tc();
        measure(n, h, t);
        chk("R5 base 40", n, 40);
        wr_en = 1'b1; wr_addr = 8'h42; wr_data = 8'h80;
        measure(n, h, t);
        wr_en = 1'b0;
        chk("R5 old ratio kept 40", n, 40);
        measure(n, h, t);
        chk("R5 new ratio 41", n, 41);
        // R5: shrink 41 -> 9
        wr_en = 1'b1; wr_addr = 8'h41; wr_data = 8'h00;
        measure(n, h, t);
        wr_en = 1'b0;
        chk("R5 old ratio kept 41", n, 41);
        measure(n, h, t);
        chk("R5 new ratio 9", n, 9);

        // R4: loop-gain bits stored, no effect on period
        wr_cfg(20, 1, 0, 0);           // ratio 49
        wr(8'h40, 8'h14);              // cp=5, pb hi=0
        rd_chk("R4 cp readback", 8'h40, 8'h14);
        sync_tc();
        measure(n, h, t);
        chk("R4 period unchanged 49", n, 49);

        // R3: reserved bits
        wr(8'h40, 8'hFF);
        rd_chk("R3 reserved read zero", 8'h40, 8'h1F);
        wr(8'h40, 8'h1C);
        rd_chk("R3 R4 restore", 8'h40, 8'h1C);

        // R9: reference-divider field
        wr(8'h42, 8'h7F);              // po=0, q=0x7F -> ratio 48
        rd_chk("R9 qref readback", 8'h42, 8'h7F);
        sync_tc();
        measure(n, h, t);
        chk("R9 period 48", n, 48);

        // R10: unmapped addresses
        wr(8'h43, 8'hFF);
        wr(8'h00, 8'hFF);
        wr(8'hC1, 8'hFF);
        rd_chk("R10 unmapped read", 8'h43, 0);
        rd_chk("R10 reg41 intact", 8'h41, 20);
        sync_tc();
        measure(n, h, t);
        chk("R10 period 48", n, 48);

        // R8: reset mid-period reloads ratio 8 and clears regs
        repeat (5) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        rd_chk("R8 reg41 cleared", 8'h41, 0);
        measure(n, h, t);
        chk("R8 period after reset 8", n, 8);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule